// File: doc/BRIEF.md
# VCO Sub-band Calibration Sequencer

This controller chooses one of 32 oscillator sub-bands by driving a 5-bit band code. Software starts a run by writing a start bit that clears itself. If the auto-restart option is enabled, a loss of lock also starts a run. Each run is paced by a one-cycle tick at the phase-detector rate. The controller first waits out a settle period. It then does a binary search of the code, most significant bit first. At each step it reads a comparator that reports whether the divided oscillator count fell below the reference count.

While a run is in progress, the block raises a force-to-mid-rail output. This output holds the charge-pump current and the loop control voltage at half supply. The busy flag is the readback of the start bit. The final code is held until the next run. Software starts a new run after each change of the feedback divider ratio.

In this bench, the oscillator and its frequency measurement are replaced by a behavioural comparator input.

Top module: `vco_band_cal`

## Requirements
- R1: After synchronous reset, busy and force_mid are 0 and cal_code is mid-scale, binary 10000 (decimal 16).
- R2: A one-cycle pulse on start_wr while idle sets busy at the next clock edge. Busy is the readback of the start bit, and it returns to 0 by itself when the run ends.
- R3: A run consumes exactly 7 pfd_tick pulses: 1 settle tick, 5 search ticks and 1 finish tick. Busy falls at the clock edge that samples the 7th tick.
- R4: force_mid is 1 on exactly the same cycles as busy.
- R5: At start, the code is loaded with 10000. Each search tick handles one bit, from bit 4 down to bit 0. The bit is kept at 1 if osc_below is 1 and cleared otherwise, and the next lower bit is set to 1 as the new trial. With a comparator that reports 1 whenever the code is at or below a target band, the final code equals that target.
- R6: Without pfd_tick pulses, a run makes no progress: busy stays 1 and the code stays unchanged.
- R7: A start_wr pulse that arrives while busy is ignored. The run still ends after its original 7 ticks, and no second run follows.
- R8: With auto_restart_en at 1, a 1-to-0 transition on lock_det while idle starts a run exactly as start_wr does.
- R9: With auto_restart_en at 0, a falling lock_det does not start a run.
- R10: While busy is 0, cal_code does not change, whatever osc_below does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pfd_tick | input | 1 | One-cycle pulse per phase-detector period |
| start_wr | input | 1 | Software write of the start bit |
| auto_restart_en | input | 1 | Enables restart on loss of lock |
| lock_det | input | 1 | Lock detector level |
| osc_below | input | 1 | Comparator: oscillator count below reference count |
| cal_code | output | 5 | Sub-band select code, readable as status |
| busy | output | 1 | Run in progress (readback of the start bit) |
| force_mid | output | 1 | Hold charge pump and control voltage at mid-supply |

## Verification
A wrong search bit or a wrong bit index shows up at the end of the run, seven ticks after the start, as a final code that differs from the comparator's target band. A bad trial load is visible earlier, because the code can be read as 10000 during the settle tick. A miscounting sequencer shows up as busy falling on the wrong tick, or never falling. A trigger that reacts while busy, or to lock loss while disabled, shows up as a busy level or a code that moves within a few cycles of the stray pulse.

// File: rtl/vbc_pkg.sv
`timescale 1ns/1ps
package vbc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_SEARCH = 2'd2,
    ST_DONE   = 2'd3
  } vbc_state_t;
endpackage

// File: rtl/vbc_trigger.sv
`timescale 1ns/1ps
module vbc_trigger (
  input  logic clk,
  input  logic rst,
  input  logic sw_start,
  input  logic auto_en,
  input  logic lock_in,
  output logic req
);
  logic lock_q;

  always_ff @(posedge clk) begin
    if (rst) lock_q <= 1'b0;
    else     lock_q <= lock_in;
  end

  // lost-lock edge only counts when the restart option is on
  always_comb req = sw_start | (auto_en & lock_q & ~lock_in);
endmodule

// File: rtl/vbc_sequencer.sv
`timescale 1ns/1ps
module vbc_sequencer
  import vbc_pkg::*;
#(
  parameter int CODE_W       = 5,
  parameter int SETTLE_TICKS = 1,
  localparam int IDX_W       = (CODE_W > 1) ? $clog2(CODE_W) : 1,
  localparam int SCNT_W      = $clog2(SETTLE_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             tick,
  output logic             load,
  output logic             step,
  output logic [IDX_W-1:0] idx,
  output logic             busy,
  output logic             force_mid
);
  localparam int TOTAL = SETTLE_TICKS + CODE_W + 1;
  localparam int TCW   = $clog2(TOTAL + 2);

  vbc_state_t        state;
  logic [SCNT_W-1:0] settle_cnt;

  always_comb begin
    load = req && (state == ST_IDLE);
    step = tick && (state == ST_SEARCH);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      settle_cnt <= '0;
      idx        <= '0;
      busy       <= 1'b0;
      force_mid  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (req) begin
          state      <= ST_SETTLE;
          settle_cnt <= '0;
          busy       <= 1'b1;
          force_mid  <= 1'b1;
        end
        ST_SETTLE: if (tick) begin
          if (settle_cnt == SCNT_W'(SETTLE_TICKS - 1)) begin
            state <= ST_SEARCH;
            idx   <= IDX_W'(CODE_W - 1);
          end else begin
            settle_cnt <= settle_cnt + 1'b1;
          end
        end
        ST_SEARCH: if (tick) begin
          if (idx == '0) state <= ST_DONE;
          else           idx   <= idx - 1'b1;
        end
        ST_DONE: if (tick) begin
          state     <= ST_IDLE;
          busy      <= 1'b0;
          force_mid <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // tick tally for the run-length check
  logic [TCW-1:0] tick_seen;
  always_ff @(posedge clk) begin
    if (rst)                tick_seen <= '0;
    else if (load)          tick_seen <= '0;
    else if (busy && tick)  tick_seen <= tick_seen + 1'b1;
  end

  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> tick_seen == TCW'(TOTAL)); // R3
  AST_TICK_BOUND: assert property (@(posedge clk) disable iff (rst)
    tick_seen <= TCW'(TOTAL)); // R3
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
    busy && !tick |=> busy); // R6
  AST_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(tick)); // R2
endmodule

// File: rtl/vbc_sar.sv
`timescale 1ns/1ps
module vbc_sar #(
  parameter int CODE_W  = 5,
  localparam int IDX_W  = (CODE_W > 1) ? $clog2(CODE_W) : 1,
  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [IDX_W-1:0]  idx,
  input  logic              below,
  output logic [CODE_W-1:0] code
);
  always_ff @(posedge clk) begin
    if (rst || load) begin
      code <= MID;
    end else if (step) begin
      for (int i = 0; i < CODE_W; i++) begin
        if (int'(idx) == i)          code[i] <= below;
        else if (int'(idx) == i + 1) code[i] <= 1'b1;
      end
    end
  end

  AST_LOAD_MID: assert property (@(posedge clk) disable iff (rst)
    load |=> code == MID); // R5
  AST_STEP_DECIDE: assert property (@(posedge clk) disable iff (rst)
    step |=> code[$past(idx)] == $past(below)); // R5
  AST_CODE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !load && !step |=> $stable(code)); // R10
endmodule

// File: rtl/vco_band_cal.sv
`timescale 1ns/1ps
module vco_band_cal #(
  parameter int CODE_W       = 5,
  parameter int SETTLE_TICKS = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pfd_tick,
  input  logic              start_wr,
  input  logic              auto_restart_en,
  input  logic              lock_det,
  input  logic              osc_below,
  output logic [CODE_W-1:0] cal_code,
  output logic              busy,
  output logic              force_mid
);
  localparam int IDX_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;

  logic             req, load, step;
  logic [IDX_W-1:0] idx;

  vbc_trigger u_trig (
    .clk(clk), .rst(rst), .sw_start(start_wr), .auto_en(auto_restart_en),
    .lock_in(lock_det), .req(req)
  );

  vbc_sequencer #(.CODE_W(CODE_W), .SETTLE_TICKS(SETTLE_TICKS)) u_seq (
    .clk(clk), .rst(rst), .req(req), .tick(pfd_tick), .load(load),
    .step(step), .idx(idx), .busy(busy), .force_mid(force_mid)
  );

  vbc_sar #(.CODE_W(CODE_W)) u_sar (
    .clk(clk), .rst(rst), .load(load), .step(step), .idx(idx),
    .below(osc_below), .code(cal_code)
  );

  AST_FORCE_MATCH: assert property (@(posedge clk) disable iff (rst)
    force_mid == busy); // R4
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !busy |=> busy || $stable(cal_code)); // R10
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
    busy && start_wr && !pfd_tick |=> busy && $stable(cal_code)); // R7
endmodule

// File: tb/test_vco_band_cal.sv
`timescale 1ns/1ps
module test_vco_band_cal;
  logic clk = 1'b0, rst = 1'b1, pfd_tick = 1'b0, start_wr = 1'b0;
  logic auto_restart_en = 1'b0, lock_det = 1'b0;
  logic [5:0] tgt = 6'd0;
  logic osc_below;
  logic [4:0] cal_code;
  logic busy, force_mid;
  int tests = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  // behavioural oscillator: count stays below reference for codes <= target band
  assign osc_below = ({1'b0, cal_code} <= tgt);

  vco_band_cal i_vco_band_cal (
    .clk(clk), .rst(rst), .pfd_tick(pfd_tick), .start_wr(start_wr),
    .auto_restart_en(auto_restart_en), .lock_det(lock_det),
    .osc_below(osc_below), .cal_code(cal_code), .busy(busy),
    .force_mid(force_mid)
  );

  // {target band, expected final code}
  localparam logic [10:0] VEC [8] = '{
    {6'd0, 5'd0}, {6'd31, 5'd31}, {6'd16, 5'd16}, {6'd15, 5'd15},
    {6'd1, 5'd1}, {6'd21, 5'd21}, {6'd10, 5'd10}, {6'd30, 5'd30}};

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic tick_pulse();
    @(negedge clk) pfd_tick = 1'b1;
    @(negedge clk) pfd_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic sw_start();
    @(negedge clk) start_wr = 1'b1;
    @(negedge clk) start_wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(force_mid == 1'b0, "R1 force_mid", force_mid, 0);
    chk(cal_code == 5'd16, "R1 code", cal_code, 16);
    rst = 1'b0;

    // R5 table walk
    for (int v = 0; v < 8; v++) begin
      tgt = VEC[v][10:5];
      sw_start();
      chk(busy == 1'b1, "R2 busy set", busy, 1);
      chk(cal_code == 5'd16, "R5 trial load", cal_code, 16);
      repeat (7) tick_pulse();
      chk(busy == 1'b0, "R2 self clear", busy, 0);
      chk(cal_code == VEC[v][4:0], "R5 final code", cal_code, VEC[v][4:0]);
    end

    // R3 / R4 exact tick count
    tgt = 6'd9;
    sw_start();
    chk(force_mid == 1'b1, "R4 force while busy", force_mid, 1);
    repeat (6) tick_pulse();
    chk(busy == 1'b1, "R3 busy after 6 ticks", busy, 1);
    tick_pulse();
    chk(busy == 1'b0, "R3 done after 7 ticks", busy, 0);
    chk(force_mid == 1'b0, "R4 force released", force_mid, 0);
    chk(cal_code == 5'd9, "R5 code 9", cal_code, 9);

    // R10 code frozen when idle
    tgt = 6'd27;
    repeat (10) @(negedge clk);
    chk(cal_code == 5'd9, "R10 idle hold", cal_code, 9);

    // R6 no ticks, no progress
    sw_start();
    repeat (20) @(negedge clk);
    chk(busy == 1'b1, "R6 busy held", busy, 1);
    chk(cal_code == 5'd16, "R6 code held", cal_code, 16);
    repeat (7) tick_pulse();
    chk(cal_code == 5'd27, "R6 resumed result", cal_code, 27);

    // R7 start while busy ignored
    tgt = 6'd4;
    sw_start();
    repeat (3) tick_pulse();
    sw_start();
    repeat (3) tick_pulse();
    chk(busy == 1'b1, "R7 still busy", busy, 1);
    tick_pulse();
    chk(busy == 1'b0, "R7 original end", busy, 0);
    repeat (5) @(negedge clk);
    chk(busy == 1'b0, "R7 no rerun", busy, 0);
    chk(cal_code == 5'd4, "R7 code", cal_code, 4);

    // R9 lock loss with restart disabled
    tgt = 6'd22;
    auto_restart_en = 1'b0;
    @(negedge clk) lock_det = 1'b1;
    @(negedge clk) lock_det = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R9 no start", busy, 0);
    chk(cal_code == 5'd4, "R9 code kept", cal_code, 4);

    // R8 lock loss with restart enabled
    auto_restart_en = 1'b1;
    @(negedge clk) lock_det = 1'b1;
    @(negedge clk) lock_det = 1'b0;
    @(negedge clk);
    chk(busy == 1'b1, "R8 auto start", busy, 1);
    repeat (7) tick_pulse();
    chk(busy == 1'b0, "R8 auto done", busy, 0);
    chk(cal_code == 5'd22, "R8 auto result", cal_code, 22);

    finish_run();
  end
endmodule